// File: doc/BRIEF.md
# Single-Precision Compare Unit with Sticky Invalid Flag

This block compares two 32-bit IEEE 754 single-precision operands and returns a one-bit verdict. A 3-bit operation code picks one of seven predicates: unordered, B-below-A, equal, less-or-equal, greater, not-equal and greater-or-equal. Each predicate has its own operand order and its own rule for which NaNs count as an invalid operation. The verdict and the exception request are combinational in the same cycle. The status and cause registers update on the next clock edge.

A four-bit floating-point status register keeps sticky flags. Compares can only set the invalid bit. The divide-by-zero, overflow and underflow bits change only through a software write, which loads the whole register. When a valid compare raises invalid, and both the FPU-exception configuration enable and the global exception enable are high, the block asserts an exception request. On the next edge it loads a cause register with the FPU cause code.

Top module: `fcmp_unit`

## Requirements
- R1: Operation code 0 (unordered) returns 1 when either operand is a NaN of any kind. It raises invalid only when either operand is a signaling NaN.
- R2: Operation code 1 returns 1 when B is strictly less than A. It raises invalid when either operand is any NaN. With a NaN operand it returns 0.
- R3: Operation code 2 (equal) and operation code 5 (not-equal) are quiet compares. Equal returns 1 only for ordered, equal operands. Not-equal is the exact inverse of equal, so it returns 1 when a NaN is present. Both raise invalid only for a signaling NaN.
- R4: Operation code 3 returns 1 when A is less than or equal to B. Operation code 4 returns 1 when A is strictly less than B. Both raise invalid on any NaN and return 0 when unordered.
- R5: Operation code 6 returns the inverse of (A strictly less than B). It therefore returns 1 when the operands are unordered. It raises invalid on any NaN.
- R6: An operand is a NaN when its exponent field (bits 30..23) is all ones and its fraction (bits 22..0) is nonzero. The NaN is quiet when bit 22 is 1 and signaling when bit 22 is 0. Infinities are not NaNs.
- R7: Ordered values compare by sign and magnitude. +0 and -0 are equal.
- R8: Status bit 0 is the invalid flag. It is set on the clock edge after a compare with `cmp_valid` high raises invalid. It stays set until a software write changes it. A compare with `cmp_valid` low never sets it.
- R9: When `sw_wr` is high, the status register loads `sw_data`. Bits 1 (divide-by-zero), 2 (overflow) and 3 (underflow) change only this way. An invalid raised in the same cycle still forces bit 0 to 1.
- R10: `exc_req` is high in the cycle of a valid compare that raises invalid, if and only if both `exc_cfg_en` and `exc_glb_en` are high. On the next edge `cause_q` loads the parameter `FPU_CAUSE`.
- R11: Operation code 7 is reserved. It returns 0, raises no invalid and requests no exception.
- R12: After reset, the status register and the cause register are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_valid | input | 1 | Compare issued this cycle; gates flag and exception updates |
| cmp_op | input | 3 | Operation code |
| opnd_a | input | 32 | Operand A |
| opnd_b | input | 32 | Operand B |
| sw_wr | input | 1 | Software write strobe for the status register |
| sw_data | input | 4 | Status value written by software |
| exc_cfg_en | input | 1 | FPU-exception configuration enable |
| exc_glb_en | input | 1 | Global exception enable |
| cmp_result | output | 1 | Combinational compare verdict |
| exc_req | output | 1 | Combinational FPU exception request |
| fsr_q | output | 4 | Status register: [0] invalid, [1] divide-by-zero, [2] overflow, [3] underflow |
| cause_q | output | 5 | Exception cause register |

## Verification
The bench builds the unit with the field widths at their single-precision defaults and sets `FPU_CAUSE` to 9 instead of the default 6. A cause value that only appears because the parameter was honoured is therefore visible at the port. The default widths expose the exact boundary between signaling and quiet NaN at fraction bit 22, and the boundary against infinity at a zero fraction. The reference model orders values through a monotonic key rather than by sign-magnitude cases. This cross-checks the treatment of signed zeros and negative operands.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    typedef enum logic [2:0] {
        OP_UNORD = 3'd0,
        OP_BLTA  = 3'd1,
        OP_EQ    = 3'd2,
        OP_LE    = 3'd3,
        OP_GT    = 3'd4,
        OP_NE    = 3'd5,
        OP_GE    = 3'd6,
        OP_RSV   = 3'd7
    } fcmp_op_e;

    typedef struct packed {
        logic sign;
        logic is_zero;
        logic is_nan;
        logic is_snan;
    } fcls_t;

    localparam int STAT_INV = 0;

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WIDTH = 1 + EXP_W + FRAC_W
) (
    input  logic [WIDTH-1:0] value,
    output fcls_t            cls,
    output logic [WIDTH-2:0] mag
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    always_comb begin
        exp_f       = value[WIDTH-2:FRAC_W];
        frac_f      = value[FRAC_W-1:0];
        mag         = value[WIDTH-2:0];
        cls.sign    = value[WIDTH-1];
        cls.is_zero = (mag == '0);
        cls.is_nan  = (&exp_f) && (frac_f != '0);
        cls.is_snan = cls.is_nan && !frac_f[FRAC_W-1];
    end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
    import fcmp_pkg::*;
#(
    parameter int MAG_W = 31
) (
    input  fcls_t            cls_a,
    input  fcls_t            cls_b,
    input  logic [MAG_W-1:0] mag_a,
    input  logic [MAG_W-1:0] mag_b,
    output logic             a_lt_b,
    output logic             b_lt_a,
    output logic             a_eq_b
);
    logic ordered;
    logic both_zero;

    always_comb begin
        ordered   = !cls_a.is_nan && !cls_b.is_nan;
        both_zero = cls_a.is_zero && cls_b.is_zero;
        a_lt_b    = 1'b0;
        b_lt_a    = 1'b0;
        a_eq_b    = ordered && (both_zero ||
                    ((cls_a.sign == cls_b.sign) && (mag_a == mag_b)));
        if (ordered && !both_zero) begin
            if (cls_a.sign != cls_b.sign) begin
                a_lt_b = cls_a.sign;
                b_lt_a = cls_b.sign;
            end else if (!cls_a.sign) begin
                a_lt_b = mag_a < mag_b;
                b_lt_a = mag_b < mag_a;
            end else begin
                a_lt_b = mag_a > mag_b;
                b_lt_a = mag_b > mag_a;
            end
        end
    end
endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
    import fcmp_pkg::*;
#(
    parameter int EXP_W     = 8,
    parameter int FRAC_W    = 23,
    parameter int STAT_W    = 4,
    parameter int CAUSE_W   = 5,
    parameter int FPU_CAUSE = 6,
    localparam int WIDTH    = 1 + EXP_W + FRAC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmp_valid,
    input  logic [2:0]         cmp_op,
    input  logic [WIDTH-1:0]   opnd_a,
    input  logic [WIDTH-1:0]   opnd_b,
    input  logic               sw_wr,
    input  logic [STAT_W-1:0]  sw_data,
    input  logic               exc_cfg_en,
    input  logic               exc_glb_en,
    output logic               cmp_result,
    output logic               exc_req,
    output logic [STAT_W-1:0]  fsr_q,
    output logic [CAUSE_W-1:0] cause_q
);
    typedef struct packed {
        logic [STAT_W-1:0]  fsr;
        logic [CAUSE_W-1:0] cause;
    } state_t;

    state_t st_d, st_q;

    fcls_t            cls [2];
    logic [WIDTH-2:0] mag [2];
    logic [WIDTH-1:0] opnd [2];

    assign opnd[0] = opnd_a;
    assign opnd[1] = opnd_b;

    for (genvar gi = 0; gi < 2; gi++) begin : g_cls
        fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .value (opnd[gi]),
            .cls   (cls[gi]),
            .mag   (mag[gi])
        );
    end

    logic a_lt_b, b_lt_a, a_eq_b;

    fcmp_order #(.MAG_W(WIDTH - 1)) u_ord (
        .cls_a  (cls[0]),
        .cls_b  (cls[1]),
        .mag_a  (mag[0]),
        .mag_b  (mag[1]),
        .a_lt_b (a_lt_b),
        .b_lt_a (b_lt_a),
        .a_eq_b (a_eq_b)
    );

    logic any_nan, any_snan, inv_hit, raise_inv;

    always_comb begin
        any_nan    = cls[0].is_nan  || cls[1].is_nan;
        any_snan   = cls[0].is_snan || cls[1].is_snan;
        cmp_result = 1'b0;
        inv_hit    = 1'b0;
        unique case (fcmp_op_e'(cmp_op))
            OP_UNORD: begin cmp_result = any_nan;            inv_hit = any_snan; end
            OP_BLTA:  begin cmp_result = b_lt_a;             inv_hit = any_nan;  end
            OP_EQ:    begin cmp_result = a_eq_b;             inv_hit = any_snan; end
            OP_LE:    begin cmp_result = a_lt_b || a_eq_b;   inv_hit = any_nan;  end
            OP_GT:    begin cmp_result = a_lt_b;             inv_hit = any_nan;  end
            OP_NE:    begin cmp_result = !a_eq_b;            inv_hit = any_snan; end
            OP_GE:    begin cmp_result = !a_lt_b;            inv_hit = any_nan;  end
            OP_RSV:   begin cmp_result = 1'b0;               inv_hit = 1'b0;     end
            default:  begin cmp_result = 1'b0;               inv_hit = 1'b0;     end
        endcase
        raise_inv = cmp_valid && inv_hit;
        exc_req   = raise_inv && exc_cfg_en && exc_glb_en;

        st_d = st_q;
        if (sw_wr) begin
            st_d.fsr = sw_data;
        end
        if (raise_inv) begin
            st_d.fsr[STAT_INV] = 1'b1;
        end
        if (exc_req) begin
            st_d.cause = CAUSE_W'(FPU_CAUSE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fsr_q   = st_q.fsr;
    assign cause_q = st_q.cause;

endmodule

// File: rtl/fcmp_unit_chk.sv
module fcmp_unit_chk #(
    parameter int WIDTH     = 32,
    parameter int FRAC_W    = 23,
    parameter int STAT_W    = 4,
    parameter int CAUSE_W   = 5,
    parameter int FPU_CAUSE = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmp_valid,
    input logic [2:0]         cmp_op,
    input logic [WIDTH-1:0]   opnd_a,
    input logic [WIDTH-1:0]   opnd_b,
    input logic               sw_wr,
    input logic               cmp_result,
    input logic               exc_req,
    input logic [STAT_W-1:0]  fsr_q,
    input logic [CAUSE_W-1:0] cause_q
);
    logic a_nan, b_nan;
    assign a_nan = (&opnd_a[WIDTH-2:FRAC_W]) && (opnd_a[FRAC_W-1:0] != '0);
    assign b_nan = (&opnd_b[WIDTH-2:FRAC_W]) && (opnd_b[FRAC_W-1:0] != '0);

    // R8
    inv_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_wr && fsr_q[0]) |=> fsr_q[0]);

    // R8
    no_spurious_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_valid && !sw_wr && !fsr_q[0]) |=> !fsr_q[0]);

    // R9
    upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_wr |=> $stable(fsr_q[STAT_W-1:1]));

    // R10
    exc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> (cause_q == CAUSE_W'(FPU_CAUSE)) && fsr_q[0]);

    // R10
    exc_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid |-> !exc_req);

    // R11
    rsv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_op == 3'd7) |-> (!cmp_result && !exc_req));

    // R3
    ne_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmp_op == 3'd5) && (a_nan || b_nan)) |-> cmp_result);

    // R5
    ge_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmp_op == 3'd6) && (a_nan || b_nan)) |-> cmp_result);

endmodule

bind fcmp_unit fcmp_unit_chk #(
    .WIDTH     (WIDTH),
    .FRAC_W    (FRAC_W),
    .STAT_W    (STAT_W),
    .CAUSE_W   (CAUSE_W),
    .FPU_CAUSE (FPU_CAUSE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmp_valid  (cmp_valid),
    .cmp_op     (cmp_op),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .sw_wr      (sw_wr),
    .cmp_result (cmp_result),
    .exc_req    (exc_req),
    .fsr_q      (fsr_q),
    .cause_q    (cause_q)
);

// File: tb/sim_fcmp_unit.sv
module sim_fcmp_unit;
    localparam int CLK_PERIOD  = 10;
    localparam int BENCH_CAUSE = 9;

    localparam logic [31:0] P_ONE  = 32'h3F80_0000;
    localparam logic [31:0] P_TWO  = 32'h4000_0000;
    localparam logic [31:0] N_ONE  = 32'hBF80_0000;
    localparam logic [31:0] N_TWO  = 32'hC000_0000;
    localparam logic [31:0] P_ZERO = 32'h0000_0000;
    localparam logic [31:0] N_ZERO = 32'h8000_0000;
    localparam logic [31:0] P_INF  = 32'h7F80_0000;
    localparam logic [31:0] N_INF  = 32'hFF80_0000;
    localparam logic [31:0] QNAN   = 32'h7FC0_0000;
    localparam logic [31:0] SNAN   = 32'h7F80_0001;
    localparam logic [31:0] SNAN_N = 32'hFFA0_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_valid = 1'b0;
    logic [2:0]  cmp_op = 3'd0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        sw_wr = 1'b0;
    logic [3:0]  sw_data = '0;
    logic        exc_cfg_en = 1'b0;
    logic        exc_glb_en = 1'b0;
    logic        cmp_result;
    logic        exc_req;
    logic [3:0]  fsr_q;
    logic [4:0]  cause_q;

    int checks = 0;
    int errors = 0;
    logic [3:0] exp_fsr = '0;
    logic [4:0] exp_cause = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fcmp_unit #(.FPU_CAUSE(BENCH_CAUSE)) u0 (
        .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_op(cmp_op),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .sw_wr(sw_wr), .sw_data(sw_data),
        .exc_cfg_en(exc_cfg_en), .exc_glb_en(exc_glb_en),
        .cmp_result(cmp_result), .exc_req(exc_req),
        .fsr_q(fsr_q), .cause_q(cause_q)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference model built from the requirements
    function automatic logic is_nan(logic [31:0] v);
        return (v[30:23] == 8'hFF) && (v[22:0] != 0);
    endfunction
    function automatic logic is_snan(logic [31:0] v);
        return is_nan(v) && !v[22];
    endfunction
    function automatic logic [31:0] okey(logic [31:0] v);
        if (v[30:0] == 0) return 32'h8000_0000;
        return v[31] ? ~v : (v | 32'h8000_0000);
    endfunction
    function automatic logic ref_lt(logic [31:0] x, logic [31:0] y);
        return !is_nan(x) && !is_nan(y) && (okey(x) < okey(y));
    endfunction
    function automatic logic ref_eq(logic [31:0] x, logic [31:0] y);
        return !is_nan(x) && !is_nan(y) && (okey(x) == okey(y));
    endfunction

    task automatic step(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic vld, input logic wr, input logic [3:0] wdata, input string tag);
        logic er, anyn, anys, inv, ex;
        @(negedge clk);
        cmp_op = op; opnd_a = a; opnd_b = b; cmp_valid = vld; sw_wr = wr; sw_data = wdata;
        anyn = is_nan(a) || is_nan(b);
        anys = is_snan(a) || is_snan(b);
        case (op)
            3'd0: begin er = anyn;                      inv = anys; end
            3'd1: begin er = ref_lt(b, a);              inv = anyn; end
            3'd2: begin er = ref_eq(a, b);              inv = anys; end
            3'd3: begin er = ref_lt(a, b) || ref_eq(a, b); inv = anyn; end
            3'd4: begin er = ref_lt(a, b);              inv = anyn; end
            3'd5: begin er = !ref_eq(a, b);             inv = anys; end
            3'd6: begin er = !ref_lt(a, b);             inv = anyn; end
            default: begin er = 1'b0;                   inv = 1'b0; end
        endcase
        inv = inv && vld;
        ex  = inv && exc_cfg_en && exc_glb_en;
        #1;
        check({tag, " result"}, {31'd0, cmp_result}, {31'd0, er});
        check({tag, " exc_req"}, {31'd0, exc_req}, {31'd0, ex});
        if (wr) exp_fsr = wdata;
        if (inv) exp_fsr[0] = 1'b1;
        if (ex) exp_cause = 5'(BENCH_CAUSE);
        @(posedge clk);
        #1;
        check({tag, " fsr"}, {28'd0, fsr_q}, {28'd0, exp_fsr});
        check({tag, " cause"}, {27'd0, cause_q}, {27'd0, exp_cause});
        cmp_valid = 1'b0; sw_wr = 1'b0;
    endtask

    task automatic t_reset;
        #1;
        // R12
        check("R12 fsr after reset", {28'd0, fsr_q}, 32'd0);
        check("R12 cause after reset", {27'd0, cause_q}, 32'd0);
    endtask

    task automatic t_ordering;
        logic [31:0] vals [8] = '{P_ONE, P_TWO, N_ONE, N_TWO, P_ZERO, N_ZERO, P_INF, N_INF};
        for (int op = 1; op < 8; op++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j += 3) begin
                    // R2 R3 R4 R5 R7 R11
                    step(3'(op), vals[i], vals[j], 1'b1, 1'b0, 4'd0, "R2-7 order");
                end
            end
        end
        // R7 signed zeros equal
        step(3'd2, P_ZERO, N_ZERO, 1'b1, 1'b0, 4'd0, "R7 zero eq");
        step(3'd1, N_ONE, P_ONE, 1'b1, 1'b0, 4'd0, "R2 b below a");
        step(3'd4, N_TWO, N_ONE, 1'b1, 1'b0, 4'd0, "R4 gt neg");
        step(3'd3, P_TWO, P_TWO, 1'b1, 1'b0, 4'd0, "R4 le equal");
        check("R8 no flag from ordered", {28'd0, fsr_q}, 32'd0);
    endtask

    task automatic t_nan;
        for (int op = 0; op < 8; op++) begin
            // R1 R3 R5 R6: quiet NaN then signaling NaN, flag cleared between
            step(3'(op), QNAN, P_ONE, 1'b1, 1'b0, 4'd0, "R6 qnan");
            step(3'd0, P_ONE, P_ONE, 1'b0, 1'b1, 4'd0, "R9 clear");
            step(3'(op), P_ONE, SNAN, 1'b1, 1'b0, 4'd0, "R6 snan");
            step(3'd0, P_ONE, P_ONE, 1'b0, 1'b1, 4'd0, "R9 clear");
            step(3'(op), SNAN_N, QNAN, 1'b1, 1'b0, 4'd0, "R1 mixed nan");
            step(3'd0, P_ONE, P_ONE, 1'b0, 1'b1, 4'd0, "R9 clear");
        end
        step(3'd0, P_INF, N_INF, 1'b1, 1'b0, 4'd0, "R6 inf not nan");
        step(3'd6, QNAN, QNAN, 1'b1, 1'b0, 4'd0, "R5 ge unordered");
        step(3'd5, QNAN, P_ONE, 1'b1, 1'b0, 4'd0, "R3 ne quiet nan");
    endtask

    task automatic t_sticky;
        step(3'd0, P_ONE, P_ONE, 1'b0, 1'b1, 4'd0, "R9 clear");
        step(3'd4, SNAN, P_ONE, 1'b0, 1'b0, 4'd0, "R8 invalid ignored when not valid");
        step(3'd4, QNAN, P_ONE, 1'b1, 1'b0, 4'd0, "R8 set");
        step(3'd2, P_ONE, P_TWO, 1'b1, 1'b0, 4'd0, "R8 holds");
        step(3'd0, P_ONE, P_ONE, 1'b0, 1'b0, 4'd0, "R8 holds idle");
        step(3'd0, P_ONE, P_ONE, 1'b0, 1'b1, 4'b1010, "R9 write upper");
        step(3'd1, SNAN, P_ONE, 1'b1, 1'b0, 4'd0, "R9 upper kept");
        step(3'd3, QNAN, P_ONE, 1'b1, 1'b1, 4'b0000, "R9 write with raise");
        step(3'd0, P_ONE, P_ONE, 1'b0, 1'b1, 4'b0110, "R9 write");
    endtask

    task automatic t_exc;
        step(3'd0, P_ONE, P_ONE, 1'b0, 1'b1, 4'd0, "R9 clear");
        exc_cfg_en = 1'b1; exc_glb_en = 1'b0;
        step(3'd1, QNAN, P_ONE, 1'b1, 1'b0, 4'd0, "R10 global off");
        exc_cfg_en = 1'b0; exc_glb_en = 1'b1;
        step(3'd1, QNAN, P_ONE, 1'b1, 1'b0, 4'd0, "R10 config off");
        exc_cfg_en = 1'b1;
        step(3'd2, QNAN, P_ONE, 1'b1, 1'b0, 4'd0, "R10 quiet no exc");
        step(3'd6, P_ONE, P_TWO, 1'b1, 1'b0, 4'd0, "R10 ordered no exc");
        step(3'd7, SNAN, SNAN, 1'b1, 1'b0, 4'd0, "R11 reserved no exc");
        step(3'd2, SNAN, P_ONE, 1'b1, 1'b0, 4'd0, "R10 exc taken");
        step(3'd4, SNAN, P_ONE, 1'b0, 1'b0, 4'd0, "R10 no exc when idle");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_ordering();
        t_nan();
        t_sticky();
        t_exc();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule